// File: doc/BRIEF.md
# Power Mode and Clock Source Controller

This block holds the power control word of a small microcontroller and turns it into clock and oscillator controls. The word carries five bits: a power-down request, an idle request, a clock-source choice, and run enables for a crystal oscillator (A) and a fast RC oscillator (B). From these bits the block decides whether the CPU clock and the peripheral clock may run, which oscillators keep running, and which oscillator drives the clock mux. It also raises a flag when the chosen source has its enable cleared, because that leaves no active clock.

The block runs in an always-on clock domain. Software writes the word while the CPU runs. Setting the power-down bit stops the CPU and peripheral clocks, and it also stops oscillators A and B and the auxiliary oscillator C. Writes are ignored while power-down holds. External wake requests pass through a synchronizer. An enabled request clears the power-down and idle bits and leaves the source and oscillator bits as they were, so the clock chosen before sleep resumes. A hardware reset instead restores the default word, which runs from oscillator A. The clock mux itself is outside the block: it receives a select line and gated enables.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the control word is 5'b00101. Its bit layout is [4] power-down, [3] idle, [2] source select (1 = oscillator A, 0 = oscillator B), [1] oscillator B enable and [0] oscillator A enable. Both clock enables are 1, clk_sel is 1 and mode_o is 0.
- R2: When power-down is 0, a write with ctl_we high loads ctl_wdata into the word at the next rising edge, and ctl_rd shows the new value.
- R3: When power-down is 1, the cpu and peripheral enables and all three oscillator runs are 0, cfg_invalid is 0 and mode_o is 4, whatever the other bits hold.
- R4: When power-down is 0 and the source is valid, clk_sel equals the source bit. mode_o is 0 for oscillator A and 1 for oscillator B.
- R5: When power-down is 0, source A with its enable at 0, or source B with its enable at 0, sets cfg_invalid to 1, forces both clock enables to 0 and sets mode_o to 5.
- R6: When power-down is 0 and idle is 1 on a valid source, cpu_clk_en is 0 and per_clk_en is 1. mode_o is 2 on oscillator A and 3 on oscillator B.
- R7: When power-down is 0, osc_a_run follows bit 0, osc_b_run follows bit 1, and osc_c_run is 1.
- R8: While power-down is 1, a wake request whose enable is high clears bits 4 and 3 and keeps bits 2..0. With the default two synchronizer stages this happens at the third rising edge after the request rises, and not before.
- R9: A wake request whose enable is low does not leave power-down.
- R10: An enabled wake request while idle clears the idle bit and keeps bits 2..0.
- R11: A write while power-down is 1 is ignored.
- R12: A reset during power-down restores the word 5'b00101, so the block runs on oscillator A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write value |
| wake_req | input | NUM_WAKE | Asynchronous wake requests |
| wake_en | input | NUM_WAKE | Per-request wake enables |
| ctl_rd | output | 5 | Current control word |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_a_run | output | 1 | Crystal oscillator run |
| osc_b_run | output | 1 | RC oscillator run |
| osc_c_run | output | 1 | Auxiliary oscillator run |
| clk_sel | output | 1 | Mux select, 1 = oscillator A |
| cfg_invalid | output | 1 | No usable clock configured |
| mode_o | output | 3 | Decoded mode code |

## Verification
The bench builds the block with its defaults: two wake lines and two synchronizer stages. With two lines, the bench can wake the block from each request line and can check a line whose enable is low. With two stages, the wake latency is exactly three edges, so the bench checks both the edge before the wake lands and the edge where it lands.

// File: rtl/pm_pkg.sv
// Shared types for the power mode controller.
// Assumes the control word layout {pd, idle, src_a, en_b, en_a}, MSB first.
package pm_pkg;
    localparam int CTL_W = 5;

    typedef struct packed {
        logic pd;
        logic idle;
        logic src_a;
        logic en_b;
        logic en_a;
    } ctl_t;

    typedef enum logic [2:0] {
        M_NORM_A  = 3'd0,
        M_NORM_B  = 3'd1,
        M_IDLE_A  = 3'd2,
        M_IDLE_B  = 3'd3,
        M_PDOWN   = 3'd4,
        M_INVALID = 3'd5
    } mode_e;

    localparam ctl_t CTL_RESET = '{pd: 1'b0, idle: 1'b0, src_a: 1'b1, en_b: 1'b0, en_a: 1'b1};
endpackage

// File: rtl/pm_wake_sync.sv
// Multi-stage synchronizer for asynchronous wake requests.
// Assumes STAGES >= 2. One chain is generated per request line.
module pm_wake_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_async,
    output logic [LINES-1:0] req_sync
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw request through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], req_async[g]};
        end

        assign req_sync[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/pm_ctl_reg.sv
// Control word register with hardware wake clearing.
// While power-down holds, writes are dropped and only a wake may change the word.
// Outside power-down, a software write has priority over a same-cycle wake.
module pm_ctl_reg
    import pm_pkg::*;
#(
    parameter ctl_t RST_VAL = CTL_RESET
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  ctl_t wdata,
    input  logic wake,
    output ctl_t q
);
    // Hold the word; a wake clears the sleep bits and keeps the source bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (q.pd) begin
            if (wake) begin
                q.pd   <= 1'b0;
                q.idle <= 1'b0;
            end
        end else if (we) begin
            q <= wdata;
        end else if (wake) begin
            q.idle <= 1'b0;
        end
    end
endmodule

// File: rtl/pm_mode_decode.sv
// Combinational decode of the control word into clock and oscillator controls.
// Assumes power-down overrides every other bit of the word.
module pm_mode_decode
    import pm_pkg::*;
(
    input  ctl_t  ctl,
    output logic  cpu_en,
    output logic  per_en,
    output logic  run_a,
    output logic  run_b,
    output logic  run_c,
    output logic  sel_a,
    output logic  invalid,
    output mode_e mode
);
    logic src_ok;

    // Check that the chosen source has its oscillator enabled.
    always_comb begin
        src_ok = ctl.src_a ? ctl.en_a : ctl.en_b;
    end

    // Derive the enables and the mode code.
    always_comb begin
        sel_a = ctl.src_a;
        if (ctl.pd) begin
            cpu_en  = 1'b0;
            per_en  = 1'b0;
            run_a   = 1'b0;
            run_b   = 1'b0;
            run_c   = 1'b0;
            invalid = 1'b0;
            mode    = M_PDOWN;
        end else begin
            run_a   = ctl.en_a;
            run_b   = ctl.en_b;
            run_c   = 1'b1;
            invalid = !src_ok;
            per_en  = src_ok;
            cpu_en  = src_ok && !ctl.idle;
            if (!src_ok)        mode = M_INVALID;
            else if (ctl.idle)  mode = ctl.src_a ? M_IDLE_A : M_IDLE_B;
            else                mode = ctl.src_a ? M_NORM_A : M_NORM_B;
        end
    end
endmodule

// File: rtl/pwr_clk_ctrl.sv
// Top of the power mode and clock source controller.
// Runs in the always-on domain. Wake requests are asynchronous and are synchronized here.
module pwr_clk_ctrl #(
    parameter int NUM_WAKE    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = pm_pkg::CTL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [CW-1:0]       ctl_wdata,
    input  logic [NUM_WAKE-1:0] wake_req,
    input  logic [NUM_WAKE-1:0] wake_en,
    output logic [CW-1:0]       ctl_rd,
    output logic                cpu_clk_en,
    output logic                per_clk_en,
    output logic                osc_a_run,
    output logic                osc_b_run,
    output logic                osc_c_run,
    output logic                clk_sel,
    output logic                cfg_invalid,
    output logic [2:0]          mode_o
);
    import pm_pkg::*;

    logic [NUM_WAKE-1:0] req_s;
    logic                wake_any;
    ctl_t                ctl_q;
    mode_e               mode_d;

    pm_wake_sync #(.LINES(NUM_WAKE), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_async (wake_req),
        .req_sync  (req_s)
    );

    // Combine the synchronized requests that are enabled.
    always_comb begin
        wake_any = |(req_s & wake_en);
    end

    pm_ctl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_t'(ctl_wdata)),
        .wake  (wake_any),
        .q     (ctl_q)
    );

    pm_mode_decode u_dec (
        .ctl     (ctl_q),
        .cpu_en  (cpu_clk_en),
        .per_en  (per_clk_en),
        .run_a   (osc_a_run),
        .run_b   (osc_b_run),
        .run_c   (osc_c_run),
        .sel_a   (clk_sel),
        .invalid (cfg_invalid),
        .mode    (mode_d)
    );

    assign ctl_rd = ctl_q;
    assign mode_o = mode_d;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
// Assertion checker for pwr_clk_ctrl. It observes the ports only.
module pwr_clk_ctrl_chk #(
    parameter int NUM_WAKE = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [4:0]          ctl_rd,
    input logic [NUM_WAKE-1:0] wake_en,
    input logic                cpu_clk_en,
    input logic                per_clk_en,
    input logic                osc_a_run,
    input logic                osc_b_run,
    input logic                osc_c_run,
    input logic                clk_sel,
    input logic                cfg_invalid
);
    p_pd_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd[4] |-> !cpu_clk_en && !per_clk_en && !osc_a_run && !osc_b_run && !osc_c_run && !cfg_invalid);

    p_sel_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rd[4] && !cfg_invalid) |-> clk_sel == ctl_rd[2]);

    p_invalid_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> !per_clk_en && !cpu_clk_en);

    p_idle_cpu_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rd[4] && ctl_rd[3]) |-> !cpu_clk_en);

    p_aux_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd[4] |-> osc_c_run);

    p_pd_exit_keeps_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rd[4] |=> (ctl_rd[4] ? $stable(ctl_rd) : (!ctl_rd[3] && ctl_rd[2:0] == $past(ctl_rd[2:0]))));

    p_wake_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_rd[4]) |-> $past(|wake_en));
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.NUM_WAKE(NUM_WAKE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_rd      (ctl_rd),
    .wake_en     (wake_en),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_a_run   (osc_a_run),
    .osc_b_run   (osc_b_run),
    .osc_c_run   (osc_c_run),
    .clk_sel     (clk_sel),
    .cfg_invalid (cfg_invalid)
);

// File: tb/tb_pwr_clk_ctrl.sv
// Self-checking bench for pwr_clk_ctrl: a vector table first, then directed tests.
module tb_pwr_clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [1:0] wake_req = '0;
    logic [1:0] wake_en = '0;
    logic [4:0] ctl_rd;
    logic       cpu_clk_en, per_clk_en, osc_a_run, osc_b_run, osc_c_run, clk_sel, cfg_invalid;
    logic [2:0] mode_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pwr_clk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .wake_req(wake_req), .wake_en(wake_en), .ctl_rd(ctl_rd),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_a_run(osc_a_run),
        .osc_b_run(osc_b_run), .osc_c_run(osc_c_run), .clk_sel(clk_sel),
        .cfg_invalid(cfg_invalid), .mode_o(mode_o)
    );

    // Row: wdata[14:10] | cpu per a b c sel inv [9:3] | mode [2:0]
    localparam logic [14:0] VEC [12] = '{
        {5'b00101, 7'b1110110, 3'd0},  // R4 normal A
        {5'b00010, 7'b1101100, 3'd1},  // R4 normal B
        {5'b00111, 7'b1111110, 3'd0},  // R7 both osc, source A
        {5'b00011, 7'b1111100, 3'd1},  // R7 both osc, source B
        {5'b00100, 7'b0000111, 3'd5},  // R5 A chosen, A off
        {5'b00001, 7'b0010101, 3'd5},  // R5 B chosen, B off
        {5'b01101, 7'b0110110, 3'd2},  // R6 idle A
        {5'b01010, 7'b0101100, 3'd3},  // R6 idle B
        {5'b01100, 7'b0000111, 3'd5},  // R5 idle on invalid source
        {5'b10101, 7'b0000010, 3'd4},  // R3 power-down
        {5'b11010, 7'b0000000, 3'd4},  // R3 power-down with idle
        {5'b10100, 7'b0000010, 3'd4}   // R3 power-down hides invalid
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    function automatic logic [9:0] outs();
        return {cpu_clk_en, per_clk_en, osc_a_run, osc_b_run, osc_c_run, clk_sel, cfg_invalid, mode_o};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 ctl_rd", 32'(ctl_rd), 32'h05);
        chk("R1 outputs", 32'(outs()), 32'({7'b1110110, 3'd0}));

        // Table walk: R2 loads, R3/R4/R5/R6/R7 decode
        for (int i = 0; i < 12; i++) begin
            do_reset();
            wr(VEC[i][14:10]);
            chk($sformatf("R2 row %0d ctl_rd", i), 32'(ctl_rd), 32'(VEC[i][14:10]));
            chk($sformatf("R3/R4/R5/R6/R7 row %0d outputs", i), 32'(outs()), 32'(VEC[i][9:0]));
        end

        // R11 write during power-down ignored, then R8 wake on line 0
        do_reset();
        wr(5'b10111);
        wr(5'b00010);
        chk("R11 write ignored in power-down", 32'(ctl_rd), 32'h17);
        wake_en = 2'b01;
        @(negedge clk);
        wake_req = 2'b01;
        repeat (2) @(negedge clk);
        chk("R8 still asleep after two edges", 32'(ctl_rd), 32'h17);
        @(negedge clk);
        chk("R8 woke at third edge", 32'(ctl_rd), 32'h07);
        chk("R8 cpu clock back", 32'(cpu_clk_en), 32'h1);
        wake_req = 2'b00;
        repeat (3) @(negedge clk);

        // R9 disabled request does nothing, then enabling it wakes (R8 on line 1)
        wr(5'b10010);
        wake_en = 2'b00;
        wake_req = 2'b10;
        repeat (6) @(negedge clk);
        chk("R9 disabled wake ignored", 32'(ctl_rd), 32'h12);
        wake_en = 2'b10;
        @(negedge clk);
        chk("R8 line 1 wake keeps source B", 32'(ctl_rd), 32'h02);
        chk("R8 line 1 mode normal B", 32'(mode_o), 32'd1);
        wake_req = 2'b00;
        repeat (3) @(negedge clk);

        // R10 wake from idle
        wr(5'b01010);
        chk("R10 idle entered", 32'(cpu_clk_en), 32'h0);
        wake_en = 2'b01;
        wake_req = 2'b01;
        repeat (3) @(negedge clk);
        chk("R10 idle cleared", 32'(ctl_rd), 32'h02);
        chk("R10 cpu clock on", 32'(cpu_clk_en), 32'h1);
        wake_req = 2'b00;
        wake_en = 2'b00;
        repeat (3) @(negedge clk);

        // R12 reset from power-down restores oscillator A
        wr(5'b10010);
        chk("R12 in power-down", 32'(mode_o), 32'd4);
        do_reset();
        chk("R12 reset word", 32'(ctl_rd), 32'h05);
        chk("R12 clock select A", 32'(clk_sel), 32'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule